// File: doc/BRIEF.md
# Zoned Write-Protection and Lock Controller

This block decides, for every write that reaches a serial memory, whether the write may start a program cycle. It receives the target address, a flag that says whether the target is the main array or the security area, the level of the hardware write-protect pin, and requests to change its own configuration register. One clock after each request it answers with exactly one of two pulses: grant, which lets the program cycle start, or block. A blocked write still finishes normally on the bus. The memory is left unchanged and no program cycle is started.

The configuration register has three fields. A mode bit selects legacy protection, where the pin guards the whole array. It can instead select enhanced protection, where a mask with one bit per zone guards each of the equal address zones on its own. The third field is a one-time lock bit that freezes the register. The security area begins with a read-only serial number. A user region comes after it, and a software lock request makes that region read-only for good. Nonvolatile state is modelled as flops. Their reset preload acts as the power-on value.

Top module: `wp_zone_guard`

## Requirements
- R1: After reset, cfgRead equals the preload CFG_INIT, which by default is all zeros: legacy mode, empty mask, unlocked. After reset secLocked, wrGrant and wrBlock are all 0.
- R2: Each cycle with wrReq high is answered in the next cycle by exactly one of wrGrant or wrBlock. Neither pulses in the cycle after a cycle without wrReq.
- R3: In legacy mode (cfgRead bit 8 = 0), a main-array write (wrSec = 0) is blocked exactly when wpPin is high. The zone mask has no effect in this mode.
- R4: In enhanced mode (cfgRead bit 8 = 1), a main-array write goes to zone z = wrAddr[15:13] and is blocked exactly when mask bit cfgRead[z] is set. wpPin has no effect in this mode.
- R5: While the lock bit (cfgRead bit 9) is 0, cfgWrReq loads cfgWrData into the register, and the new value shows on cfgRead in the next cycle. The field layout is bits 7:0 for the zone mask, bit 8 for the mode and bit 9 for the lock.
- R6: Once the lock bit is 1, cfgWrReq is ignored. cfgRead and the protection it selects stay the same until reset.
- R7: A security write (wrSec = 1) to offset wrAddr[7:0] in the range 0 to 15 (the serial number) is always blocked, whatever the mode, the pin or the locks.
- R8: A security write to offset 16 to 143 (the user region) is granted while secLocked is 0, whatever the pin and the configuration. Once secLocked is 1 it is blocked.
- R9: A secLockReq pulse sets secLocked in the next cycle. Only reset clears it.
- R10: A security write to offset 144 to 255 is blocked. For security writes, wrAddr bits 15:8 are ignored.
- R11: A write request in the same cycle as a configuration load is judged against the configuration held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (power-on preload) |
| wrReq | input | 1 | Write attempt, one cycle per attempt |
| wrSec | input | 1 | 1 = target is the security area, 0 = main array |
| wrAddr | input | 16 | Byte address of the attempted write |
| wpPin | input | 1 | Hardware write-protect level |
| cfgWrReq | input | 1 | Request to load the configuration register |
| cfgWrData | input | 10 | Value to load: mask in 7:0, mode in 8, lock in 9 |
| secLockReq | input | 1 | Permanently lock the security user region |
| wrGrant | output | 1 | Write allowed, program cycle may start |
| wrBlock | output | 1 | Write refused, memory untouched |
| cfgRead | output | 10 | Current configuration register |
| secLocked | output | 1 | Security user region is locked |

## Verification
The bench builds the block with its default parameters: a 16-bit address, three zone bits (eight zones) and an 8-bit security offset holding a 16-byte serial number and a 128-byte user region. These values make the exact edges reachable in a short run. On the array side these are the last and first byte of neighbouring zones (0x1FFF/0x2000, 0x5FFF/0x6000, 0xDFFF/0xE000). In the security area they are the serial/user boundary (15/16) and the end of the user region (143/144). Upper address bits are also driven during security writes to show that they are ignored.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;
  // strobes raised by the control toward the datapath registers
  typedef struct packed {
    logic cfgLoad;
    logic secLockSet;
    logic grant;
    logic block;
  } guardStrobes_t;
endpackage

// File: rtl/wp_guard_ctrl.sv
module wp_guard_ctrl
  import wp_guard_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int ZONE_W       = 3,
  parameter int SEC_W        = 8,
  parameter int SERIAL_BYTES = 16,
  parameter int USER_BYTES   = 128,
  localparam int NUM_ZONES   = 1 << ZONE_W,
  localparam int CFG_W       = NUM_ZONES + 2
) (
  input  logic              wrReq,
  input  logic              wrSec,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wpPin,
  input  logic              cfgWrReq,
  input  logic              secLockReq,
  input  logic [CFG_W-1:0]  cfgQ,
  input  logic              secLockQ,
  output guardStrobes_t     strobes
);
  localparam int MODE_BIT = NUM_ZONES;
  localparam int LOCK_BIT = NUM_ZONES + 1;
  localparam int USER_END = SERIAL_BYTES + USER_BYTES;

  logic [ZONE_W-1:0]    zoneIdx;
  logic [NUM_ZONES-1:0] zoneHit;
  logic [SEC_W-1:0]     secOff;
  logic                 inUser;
  logic                 arrayOk;
  logic                 secOk;
  logic                 allowed;

  assign zoneIdx = wrAddr[ADDR_W-1 -: ZONE_W];
  assign secOff  = wrAddr[SEC_W-1:0];

  // one decoded compare per zone, gated by that zone's mask bit
  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    assign zoneHit[z] = cfgQ[z] && (zoneIdx == ZONE_W'(z));
  end

  assign inUser  = (int'(secOff) >= SERIAL_BYTES) && (int'(secOff) < USER_END);
  assign arrayOk = cfgQ[MODE_BIT] ? !(|zoneHit) : !wpPin;
  assign secOk   = inUser && !secLockQ;
  assign allowed = wrSec ? secOk : arrayOk;

  always_comb begin
    strobes            = '0;
    strobes.grant      = wrReq && allowed;
    strobes.block      = wrReq && !allowed;
    strobes.cfgLoad    = cfgWrReq && !cfgQ[LOCK_BIT];
    strobes.secLockSet = secLockReq;
  end
endmodule

// File: rtl/wp_guard_dp.sv
module wp_guard_dp
  import wp_guard_pkg::*;
#(
  parameter int          ZONE_W   = 3,
  parameter logic [31:0] CFG_INIT = '0,
  localparam int NUM_ZONES = 1 << ZONE_W,
  localparam int CFG_W     = NUM_ZONES + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  guardStrobes_t    strobes,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgQ,
  output logic             secLockQ,
  output logic             wrGrant,
  output logic             wrBlock
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ     <= CFG_INIT[CFG_W-1:0];
      secLockQ <= 1'b0;
      wrGrant  <= 1'b0;
      wrBlock  <= 1'b0;
    end else begin
      if (strobes.cfgLoad)    cfgQ     <= cfgWrData;
      if (strobes.secLockSet) secLockQ <= 1'b1;
      wrGrant <= strobes.grant;
      wrBlock <= strobes.block;
    end
  end
endmodule

// File: rtl/wp_zone_guard.sv
module wp_zone_guard
  import wp_guard_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int          ZONE_W       = 3,
  parameter int          SEC_W        = 8,
  parameter int          SERIAL_BYTES = 16,
  parameter int          USER_BYTES   = 128,
  parameter logic [31:0] CFG_INIT     = '0,
  localparam int NUM_ZONES = 1 << ZONE_W,
  localparam int CFG_W     = NUM_ZONES + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic              wrSec,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wpPin,
  input  logic              cfgWrReq,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              secLockReq,
  output logic              wrGrant,
  output logic              wrBlock,
  output logic [CFG_W-1:0]  cfgRead,
  output logic              secLocked
);
  guardStrobes_t    strobes;
  logic [CFG_W-1:0] cfgQ;
  logic             secLockQ;

  wp_guard_ctrl #(
    .ADDR_W(ADDR_W), .ZONE_W(ZONE_W), .SEC_W(SEC_W),
    .SERIAL_BYTES(SERIAL_BYTES), .USER_BYTES(USER_BYTES)
  ) i_ctrl (
    .wrReq(wrReq), .wrSec(wrSec), .wrAddr(wrAddr), .wpPin(wpPin),
    .cfgWrReq(cfgWrReq), .secLockReq(secLockReq),
    .cfgQ(cfgQ), .secLockQ(secLockQ), .strobes(strobes)
  );

  wp_guard_dp #(
    .ZONE_W(ZONE_W), .CFG_INIT(CFG_INIT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgWrData(cfgWrData),
    .cfgQ(cfgQ), .secLockQ(secLockQ), .wrGrant(wrGrant), .wrBlock(wrBlock)
  );

  assign cfgRead   = cfgQ;
  assign secLocked = secLockQ;
endmodule

// File: rtl/wp_zone_guard_chk.sv
module wp_zone_guard_chk #(
  parameter int ADDR_W       = 16,
  parameter int ZONE_W       = 3,
  parameter int SEC_W        = 8,
  parameter int SERIAL_BYTES = 16,
  localparam int NUM_ZONES   = 1 << ZONE_W,
  localparam int CFG_W       = NUM_ZONES + 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrReq,
  input logic              wrSec,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wpPin,
  input logic              cfgWrReq,
  input logic [CFG_W-1:0]  cfgWrData,
  input logic              wrGrant,
  input logic              wrBlock,
  input logic [CFG_W-1:0]  cfgRead,
  input logic              secLocked
);
  localparam int MODE_BIT = NUM_ZONES;
  localparam int LOCK_BIT = NUM_ZONES + 1;

  p_one_answer_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> (wrGrant != wrBlock));

  p_no_stray_r2: assert property (@(posedge clk) disable iff (!rstN)
    !wrReq |=> (!wrGrant && !wrBlock));

  p_pin_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrSec && !cfgRead[MODE_BIT] && wpPin) |=> wrBlock);

  p_cfg_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrReq && !cfgRead[LOCK_BIT]) |=> (cfgRead == $past(cfgWrData)));

  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgRead[LOCK_BIT] |=> $stable(cfgRead));

  p_serial_ro_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && wrSec && (int'(wrAddr[SEC_W-1:0]) < SERIAL_BYTES)) |=> wrBlock);

  p_sec_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    secLocked |=> secLocked);
endmodule

bind wp_zone_guard wp_zone_guard_chk #(
  .ADDR_W(ADDR_W), .ZONE_W(ZONE_W), .SEC_W(SEC_W), .SERIAL_BYTES(SERIAL_BYTES)
) i_chk (
  .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrSec(wrSec), .wrAddr(wrAddr),
  .wpPin(wpPin), .cfgWrReq(cfgWrReq), .cfgWrData(cfgWrData),
  .wrGrant(wrGrant), .wrBlock(wrBlock), .cfgRead(cfgRead), .secLocked(secLocked)
);

// File: tb/test_wp_zone_guard.sv
module test_wp_zone_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrReq = 1'b0;
  logic        wrSec = 1'b0;
  logic [15:0] wrAddr = '0;
  logic        wpPin = 1'b0;
  logic        cfgWrReq = 1'b0;
  logic [9:0]  cfgWrData = '0;
  logic        secLockReq = 1'b0;
  logic        wrGrant;
  logic        wrBlock;
  logic [9:0]  cfgRead;
  logic        secLocked;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wp_zone_guard i_wp_zone_guard (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrSec(wrSec), .wrAddr(wrAddr),
    .wpPin(wpPin), .cfgWrReq(cfgWrReq), .cfgWrData(cfgWrData),
    .secLockReq(secLockReq), .wrGrant(wrGrant), .wrBlock(wrBlock),
    .cfgRead(cfgRead), .secLocked(secLocked)
  );

  // vector: {cfg[9:0], wp, sec, addr[15:0], expectGrant, reqNum[3:0]}
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {10'h000, 1'b0, 1'b0, 16'h1234, 1'b1, 4'd3},  // R3 pin low
    {10'h000, 1'b1, 1'b0, 16'h1234, 1'b0, 4'd3},  // R3 pin high
    {10'h0FF, 1'b0, 1'b0, 16'h8000, 1'b1, 4'd3},  // R3 mask ignored
    {10'h105, 1'b0, 1'b0, 16'h0000, 1'b0, 4'd4},  // R4 zone 0 masked
    {10'h105, 1'b1, 1'b0, 16'h2000, 1'b1, 4'd4},  // R4 pin ignored
    {10'h105, 1'b0, 1'b0, 16'h1FFF, 1'b0, 4'd4},  // R4 zone 0 top
    {10'h105, 1'b0, 1'b0, 16'h4000, 1'b0, 4'd4},  // R4 zone 2 base
    {10'h105, 1'b0, 1'b0, 16'h5FFF, 1'b0, 4'd4},  // R4 zone 2 top
    {10'h105, 1'b0, 1'b0, 16'h6000, 1'b1, 4'd4},  // R4 zone 3 base
    {10'h180, 1'b0, 1'b0, 16'hE000, 1'b0, 4'd4},  // R4 zone 7
    {10'h180, 1'b1, 1'b0, 16'hDFFF, 1'b1, 4'd4},  // R4 zone 6
    {10'h100, 1'b1, 1'b1, 16'h000F, 1'b0, 4'd7},  // R7 last serial byte
    {10'h000, 1'b1, 1'b1, 16'h0010, 1'b1, 4'd8},  // R8 first user byte
    {10'h0FF, 1'b0, 1'b1, 16'h008F, 1'b1, 4'd8},  // R8 last user byte
    {10'h000, 1'b0, 1'b1, 16'h0090, 1'b0, 4'd10}, // R10 past user region
    {10'h000, 1'b0, 1'b1, 16'hFF10, 1'b1, 4'd10}  // R10 upper bits ignored
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic loadCfg(input logic [9:0] val);
    @(negedge clk);
    cfgWrReq = 1'b1; cfgWrData = val;
    @(negedge clk);
    cfgWrReq = 1'b0;
  endtask

  // drive one attempt; result sampled one edge later
  task automatic attempt(input logic sec, input logic [15:0] addr, input logic wp,
                         output logic g, output logic b);
    @(negedge clk);
    wrReq = 1'b1; wrSec = sec; wrAddr = addr; wpPin = wp;
    @(negedge clk);
    wrReq = 1'b0;
    g = wrGrant; b = wrBlock;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic g, b;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cfg", int'(cfgRead), 0);
    check("R1 secLocked", int'(secLocked), 0);
    check("R1 grant/block", int'({wrGrant, wrBlock}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 no stray", int'({wrGrant, wrBlock}), 0);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      loadCfg(v[32:23]);
      check("R5 load", int'(cfgRead), int'(v[32:23]));
      attempt(v[21], v[20:5], v[22], g, b);
      check($sformatf("R%0d vec%0d grant", v[3:0], i), int'(g), int'(v[4]));
      check($sformatf("R2 vec%0d block", i), int'(b), int'(!v[4]));
    end

    // R11: same-cycle config load judged on old config
    loadCfg(10'h000);
    @(negedge clk);
    cfgWrReq = 1'b1; cfgWrData = 10'h101;
    wrReq = 1'b1; wrSec = 1'b0; wrAddr = 16'h0040; wpPin = 1'b0;
    @(negedge clk);
    cfgWrReq = 1'b0; wrReq = 1'b0;
    check("R11 old cfg grant", int'(wrGrant), 1);
    attempt(1'b0, 16'h0040, 1'b0, g, b);
    check("R11 new cfg block", int'(b), 1);

    // R9 security lock
    attempt(1'b1, 16'h0020, 1'b0, g, b);
    check("R8 user before lock", int'(g), 1);
    @(negedge clk); secLockReq = 1'b1;
    @(negedge clk); secLockReq = 1'b0;
    check("R9 locked", int'(secLocked), 1);
    attempt(1'b1, 16'h0020, 1'b0, g, b);
    check("R8 user after lock", int'(b), 1);
    repeat (4) @(negedge clk);
    check("R9 sticky", int'(secLocked), 1);

    // R6 configuration lock
    loadCfg(10'h302);
    check("R6 lock load", int'(cfgRead), 'h302);
    loadCfg(10'h000);
    check("R6 write ignored", int'(cfgRead), 'h302);
    attempt(1'b0, 16'h2000, 1'b0, g, b);
    check("R6 zone1 still blocked", int'(b), 1);
    attempt(1'b0, 16'h0000, 1'b1, g, b);
    check("R6 zone0 still open", int'(g), 1);

    // R1 reset clears locks
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check("R1 cfg after reset", int'(cfgRead), 0);
    check("R1 sec after reset", int'(secLocked), 0);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule